// File: doc/BRIEF.md
# Three-level virtual address translation walker

This block turns a 39-bit virtual address into a physical address. It reads the page tables from memory, one entry per level. A request carries:
- the virtual address;
- the kind of access (load, store or fetch);
- whether the requester runs in user or supervisor mode;
- the make-executable-readable and supervisor-may-touch-user flags;
- the root table base;
- the level at which the walk starts.

The walker issues one 8-byte read per level on a plain request/response memory port. Each entry it reads is either a pointer to the next table or a leaf, and the walker classifies it. The walk ends with a one-cycle completion pulse. That pulse carries either the translated address, the leaf entry, its address, its level and a global flag, or a 3-bit failure code.

The walker handles one walk at a time. It can start at any level. Large pages (leaves above level 0) must be aligned: the low bits of their physical page number must be zero. On success, those low bits are filled in from the virtual page number. The walker never writes the accessed or dirty bits. An entry that would need such an update is reported as a failure, so that software can deal with it.

Top module: `sv39_walker`

## Requirements
- R1: After reset, `busy`, `mem_req_valid` and `done_valid` are all low.
- R2: The entry read at level L is at `base + 8*idx`. Here idx is bits [9L+8:9L] of the virtual page number, which is vaddr[38:12], and base is the root for the first read. The walk makes exactly one read per level it visits.
- R3: An entry is a pointer when V (bit 0) is set and R, W and X (bits 1, 2, 3) are all clear. If a pointer is found above level 0, the walk reads again at level L-1, using base = entry PPN (bits [53:10]) shifted left by 12. The global result is the OR of G (bit 5) over all entries visited.
- R4: A pointer found at level 0 ends the walk with fault code 2 (bad entry).
- R5: An entry with V clear, or with W set and R clear, ends the walk with fault code 2.
- R6: A memory response with the error flag set ends the walk with fault code 1. No further read is made.
- R7: The permission check on a leaf uses the access code: 0 = load, 1 = store, 2 = fetch, and 3 behaves as a load.
  - A load needs R, or needs X together with the make-executable-readable flag. A store needs W. A fetch needs X.
  - A user request needs U (bit 4) set.
  - A supervisor request on a page with U set needs the supervisor-may-touch-user flag, and is never allowed for a fetch.
  - A failed check gives fault code 3, and this check is made before the alignment and update checks.
- R8: For a leaf at level L > 0, if any of the low 9L bits of the PPN is nonzero, the walk ends with fault code 4. This check is made before the update check.
- R9: A successful leaf gives fault code 0 and `done_ok` = 1. The physical address is {PPN OR (VPN masked to its low 9L bits), vaddr[11:0]}. The result also carries the leaf entry, its address and its level. On any failure, `done_paddr` is 0.
- R10: A leaf that passes R7 and R8 but has A (bit 6) clear, or is the target of a store with D (bit 7) clear, ends the walk with fault code 5.
- R11: A request is taken only when the walker is idle. `busy` stays high from the cycle after a walk is accepted until its completion. Every read request lasts one cycle. A `req_valid` that arrives while `busy` is high is ignored. Each completion is a single-cycle `done_valid` pulse.
- R12: A starting level of 3 or more ends with fault code 2 one cycle after acceptance. No memory read is made and `busy` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken when idle) |
| req_vaddr | input | 39 | Virtual address |
| req_acc | input | 2 | Access code: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 = user request, 0 = supervisor |
| req_mxr | input | 1 | Loads may read execute-only pages |
| req_sum | input | 1 | Supervisor may access user pages |
| req_root | input | 56 | Physical base of the starting table |
| req_level | input | 2 | Starting level |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | 56 | Entry address to read |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_err | input | 1 | Read failed |
| mem_rsp_data | input | 64 | Entry read from memory |
| done_valid | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Translation succeeded |
| done_fault | output | 3 | Fault code (0 when successful) |
| done_paddr | output | 56 | Translated physical address |
| done_pte | output | 64 | Final entry read |
| done_pte_addr | output | 56 | Address of the final entry |
| done_level | output | 2 | Level of the final entry |
| done_global | output | 1 | OR of the G bits along the path |

## Verification
The bench builds the walker with its default parameters: three levels, 9-bit indices, 4 KiB pages and 56-bit physical addresses. With these values, table bases above 32 bits and every leaf level are within reach. The bench places tables in a sparse memory model. It covers:
- walks of all three depths, including walks that start at levels 0 and 2, so that pointer descent, gigapage and megapage filling, and alignment failures can each be checked;
- a memory error injected at a chosen entry address;
- pairs of faults on the same leaf, which check the fixed order of the permission, alignment and update checks;
- a second request driven while a walk is in progress, which shows that it is ignored.

// File: rtl/sv39_pkg.sv
package sv39_pkg;
  // Fault codes reported on done_fault
  localparam logic [2:0] FLT_NONE    = 3'd0;
  localparam logic [2:0] FLT_ACCESS  = 3'd1;
  localparam logic [2:0] FLT_BAD_PTE = 3'd2;
  localparam logic [2:0] FLT_PERM    = 3'd3;
  localparam logic [2:0] FLT_ALIGN   = 3'd4;
  localparam logic [2:0] FLT_UPDATE  = 3'd5;

  // Access kinds
  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  // Entry layout
  localparam int PTE_W       = 64;
  localparam int PTE_PPN_LSB = 10;
  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_U = 4;
  localparam int BIT_G = 5;
  localparam int BIT_A = 6;
  localparam int BIT_D = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/sv39_pte_addr.sv
module sv39_pte_addr #(
  parameter int LEVELS = 3,
  parameter int IDX_W  = 9,
  parameter int PA_W   = 56,
  parameter int LVL_W  = 2,
  localparam int VPN_W = LEVELS * IDX_W
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  input  logic [PA_W-1:0]  base,
  output logic [PA_W-1:0]  addr
);
  // Index slice selected by the level
  function automatic logic [IDX_W-1:0] level_index(input logic [VPN_W-1:0] v,
                                                  input logic [LVL_W-1:0] lvl);
    logic [VPN_W-1:0] sh;
    sh = v >> (lvl * IDX_W);
    return sh[IDX_W-1:0];
  endfunction

  logic [IDX_W-1:0] idx;
  assign idx  = level_index(vpn, level);
  // Entries are 8 bytes wide
  assign addr = base + PA_W'({idx, 3'b000});
endmodule

// File: rtl/sv39_pte_eval.sv
module sv39_pte_eval
  import sv39_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int IDX_W  = 9,
  parameter int PPN_W  = 44,
  parameter int LVL_W  = 2,
  localparam int VPN_W = LEVELS * IDX_W
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [LVL_W-1:0] level,
  input  logic [1:0]       acc,
  input  logic             user,
  input  logic             mxr,
  input  logic             sum,
  input  logic [VPN_W-1:0] vpn,
  output logic             descend,
  output logic [2:0]       fault,
  output logic [PPN_W-1:0] leaf_ppn,
  output logic [PPN_W-1:0] next_ppn,
  output logic             glob
);
  function automatic logic perm_ok(input logic [1:0] a, input logic usr, input logic mx,
                                   input logic su, input logic r, input logic w,
                                   input logic x, input logic u);
    logic kind_ok;
    logic mode_ok;
    case (a)
      ACC_STORE: kind_ok = w;
      ACC_FETCH: kind_ok = x;
      default:   kind_ok = r | (mx & x);
    endcase
    if (usr) mode_ok = u;
    else     mode_ok = !u || (su && a != ACC_FETCH);
    return kind_ok && mode_ok;
  endfunction

  function automatic logic [PPN_W-1:0] low_mask(input logic [LVL_W-1:0] lvl);
    return (PPN_W'(1) << (lvl * IDX_W)) - PPN_W'(1);
  endfunction

  logic f_v, f_r, f_w, f_x, f_u, f_a, f_d;
  logic [PPN_W-1:0] ppn, mask;
  logic ev_bad, ev_leaf, ev_perm, ev_misal, ev_upd;
  logic unused_pte_bits;

  assign f_v = pte[BIT_V];
  assign f_r = pte[BIT_R];
  assign f_w = pte[BIT_W];
  assign f_x = pte[BIT_X];
  assign f_u = pte[BIT_U];
  assign f_a = pte[BIT_A];
  assign f_d = pte[BIT_D];
  assign glob = pte[BIT_G];
  assign ppn  = pte[PTE_PPN_LSB +: PPN_W];
  assign unused_pte_bits = ^{pte[PTE_W-1:PTE_PPN_LSB+PPN_W], pte[PTE_PPN_LSB-1:BIT_D+1]};

  assign mask     = low_mask(level);
  assign ev_bad   = !f_v || (f_w && !f_r);
  assign ev_leaf  = f_r || f_x;
  assign ev_perm  = perm_ok(acc, user, mxr, sum, f_r, f_w, f_x, f_u);
  assign ev_misal = |(ppn & mask);
  assign ev_upd   = !f_a || (acc == ACC_STORE && !f_d);

  assign descend  = !ev_bad && !ev_leaf && (level != '0);
  assign next_ppn = ppn;
  assign leaf_ppn = ppn | (PPN_W'(vpn) & mask);

  always_comb begin
    if (ev_bad)        fault = FLT_BAD_PTE;
    else if (!ev_leaf) fault = descend ? FLT_NONE : FLT_BAD_PTE;
    else if (!ev_perm) fault = FLT_PERM;
    else if (ev_misal) fault = FLT_ALIGN;
    else if (ev_upd)   fault = FLT_UPDATE;
    else               fault = FLT_NONE;
  end
endmodule

// File: rtl/sv39_walker.sv
module sv39_walker
  import sv39_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int IDX_W  = 9,
  parameter int OFS_W  = 12,
  parameter int PA_W   = 56,
  localparam int VPN_W = LEVELS * IDX_W,
  localparam int VA_W  = VPN_W + OFS_W,
  localparam int PPN_W = PA_W - OFS_W,
  localparam int LVL_W = (LEVELS > 2) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              req_user,
  input  logic              req_mxr,
  input  logic              req_sum,
  input  logic [PA_W-1:0]   req_root,
  input  logic [LVL_W-1:0]  req_level,
  output logic              busy,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              done_valid,
  output logic              done_ok,
  output logic [2:0]        done_fault,
  output logic [PA_W-1:0]   done_paddr,
  output logic [PTE_W-1:0]  done_pte,
  output logic [PA_W-1:0]   done_pte_addr,
  output logic [LVL_W-1:0]  done_level,
  output logic              done_global
);
  localparam logic [LVL_W:0] LEVELS_V = (LVL_W+1)'(LEVELS);

  walk_state_e       st_q;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        acc_q;
  logic              user_q, mxr_q, sum_q, glob_q;
  logic [PA_W-1:0]   base_q;
  logic [LVL_W-1:0]  lvl_q;

  logic [VPN_W-1:0]  vpn;
  logic [OFS_W-1:0]  ofs;
  logic [PA_W-1:0]   pte_addr;
  logic              ev_descend, ev_g;
  logic [2:0]        ev_fault;
  logic [PPN_W-1:0]  ev_leaf_ppn, ev_next_ppn;
  logic              req_take, rsp_take, lvl_bad;

  assign vpn = va_q[VA_W-1:OFS_W];
  assign ofs = va_q[OFS_W-1:0];

  sv39_pte_addr #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PA_W(PA_W), .LVL_W(LVL_W)) u_addr (
    .vpn  (vpn),
    .level(lvl_q),
    .base (base_q),
    .addr (pte_addr)
  );

  sv39_pte_eval #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W), .LVL_W(LVL_W)) u_eval (
    .pte     (mem_rsp_data),
    .level   (lvl_q),
    .acc     (acc_q),
    .user    (user_q),
    .mxr     (mxr_q),
    .sum     (sum_q),
    .vpn     (vpn),
    .descend (ev_descend),
    .fault   (ev_fault),
    .leaf_ppn(ev_leaf_ppn),
    .next_ppn(ev_next_ppn),
    .glob    (ev_g)
  );

  // Named events for the assertions
  assign req_take = (st_q == ST_IDLE) && req_valid;
  assign rsp_take = (st_q == ST_WAIT) && mem_rsp_valid;
  assign lvl_bad  = {1'b0, req_level} >= LEVELS_V;

  assign busy          = (st_q != ST_IDLE);
  assign mem_req_valid = (st_q == ST_ISSUE);
  assign mem_req_addr  = pte_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      va_q          <= '0;
      acc_q         <= '0;
      user_q        <= 1'b0;
      mxr_q         <= 1'b0;
      sum_q         <= 1'b0;
      glob_q        <= 1'b0;
      base_q        <= '0;
      lvl_q         <= '0;
      done_valid    <= 1'b0;
      done_ok       <= 1'b0;
      done_fault    <= FLT_NONE;
      done_paddr    <= '0;
      done_pte      <= '0;
      done_pte_addr <= '0;
      done_level    <= '0;
      done_global   <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            acc_q  <= req_acc;
            user_q <= req_user;
            mxr_q  <= req_mxr;
            sum_q  <= req_sum;
            base_q <= req_root;
            lvl_q  <= req_level;
            glob_q <= 1'b0;
            if (lvl_bad) begin
              done_valid    <= 1'b1;
              done_ok       <= 1'b0;
              done_fault    <= FLT_BAD_PTE;
              done_paddr    <= '0;
              done_pte      <= '0;
              done_pte_addr <= '0;
              done_level    <= req_level;
              done_global   <= 1'b0;
            end else begin
              st_q <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              st_q          <= ST_IDLE;
              done_valid    <= 1'b1;
              done_ok       <= 1'b0;
              done_fault    <= FLT_ACCESS;
              done_paddr    <= '0;
              done_pte      <= '0;
              done_pte_addr <= pte_addr;
              done_level    <= lvl_q;
              done_global   <= glob_q;
            end else if (ev_descend) begin
              base_q <= {ev_next_ppn, OFS_W'(0)};
              lvl_q  <= lvl_q - LVL_W'(1);
              glob_q <= glob_q | ev_g;
              st_q   <= ST_ISSUE;
            end else begin
              st_q          <= ST_IDLE;
              done_valid    <= 1'b1;
              done_ok       <= (ev_fault == FLT_NONE);
              done_fault    <= ev_fault;
              done_paddr    <= (ev_fault == FLT_NONE) ? {ev_leaf_ppn, ofs} : '0;
              done_pte      <= mem_rsp_data;
              done_pte_addr <= pte_addr;
              done_level    <= lvl_q;
              done_global   <= glob_q | ev_g;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R11
  issue_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> (!mem_req_valid && busy));

  // R3
  descend_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && !mem_rsp_err && ev_descend) |=> (mem_req_valid && lvl_q == $past(lvl_q) - LVL_W'(1)));

  // R6
  access_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && mem_rsp_err) |=> (done_valid && done_fault == FLT_ACCESS && !busy));

  // R12
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_take && lvl_bad) |=> (done_valid && done_fault == FLT_BAD_PTE && !busy && !mem_req_valid));

  // R9
  leaf_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && !mem_rsp_err && !ev_descend && ev_fault == FLT_NONE) |=>
      (done_valid && done_ok && done_pte == $past(mem_rsp_data)));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> $past(req_valid));
endmodule

// File: tb/sv39_walker_test.sv
module sv39_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [38:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0, req_mxr = 1'b0, req_sum = 1'b0;
  logic [55:0] req_root = '0;
  logic [1:0]  req_level = '0;
  logic        busy, mem_req_valid;
  logic [55:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done_valid, done_ok, done_global;
  logic [2:0]  done_fault;
  logic [55:0] done_paddr, done_pte_addr;
  logic [63:0] done_pte;
  logic [1:0]  done_level;

  sv39_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_user(req_user), .req_mxr(req_mxr), .req_sum(req_sum),
    .req_root(req_root), .req_level(req_level), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_ok(done_ok), .done_fault(done_fault),
    .done_paddr(done_paddr), .done_pte(done_pte), .done_pte_addr(done_pte_addr),
    .done_level(done_level), .done_global(done_global)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // Sparse memory model
  logic [63:0] mem [logic [55:0]];
  logic        err_en = 1'b0;
  logic [55:0] err_addr = '0;
  int          rd_cnt = 0;
  logic [55:0] rd_log [0:7];

  // Captured completion
  logic        r_got, r_ok, r_glob;
  logic [2:0]  r_fault;
  logic [55:0] r_paddr, r_pte_addr;
  logic [63:0] r_pte;
  logic [1:0]  r_level;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic [7:0] flags);
    return {10'd0, ppn, 2'b00, flags};
  endfunction

  // Memory responder: capture at one falling edge, answer at the next
  initial begin
    logic        pend;
    logic [55:0] paddr;
    pend = 1'b0;
    paddr = '0;
    forever begin
      @(negedge clk);
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_err   = err_en && (paddr == err_addr);
        mem_rsp_data  = mem_rsp_err ? 64'd0 : (mem.exists(paddr) ? mem[paddr] : 64'd0);
        pend = 1'b0;
      end else begin
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        mem_rsp_data  = '0;
      end
      if (mem_req_valid) begin
        pend  = 1'b1;
        paddr = mem_req_addr;
        if (rd_cnt < 8) rd_log[rd_cnt] = mem_req_addr;
        rd_cnt++;
      end
    end
  end

  task automatic walk(input logic [38:0] va, input logic [1:0] acc, input logic usr,
                      input logic mx, input logic su, input logic [55:0] root,
                      input logic [1:0] lvl, input logic inject);
    @(negedge clk);
    rd_cnt = 0;
    req_vaddr = va; req_acc = acc; req_user = usr; req_mxr = mx; req_sum = su;
    req_root = root; req_level = lvl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    r_got = 1'b0;
    if (inject) begin
      check("R11", "busy after accept", {63'd0, busy}, 64'd1);
      req_vaddr = 39'h7F_FFFF_FFFF; req_level = 2'd0; req_root = 56'h99_0000_0000;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (done_valid) r_got = 1'b1;
    end
    for (int i = 0; i < 200 && !r_got; i++) begin
      if (done_valid) r_got = 1'b1;
      else @(negedge clk);
    end
    if (!r_got) begin
      n_chk++; n_bad++;
      $display("FAIL R11 no completion: actual=0 expected=1");
    end
    r_ok = done_ok; r_fault = done_fault; r_paddr = done_paddr; r_pte = done_pte;
    r_pte_addr = done_pte_addr; r_level = done_level; r_glob = done_global;
  endtask

  localparam logic [55:0] ROOT = 56'h1000_0000;

  task automatic t_reset;
    check("R1", "busy", {63'd0, busy}, 64'd0);
    check("R1", "mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
    check("R1", "done_valid", {63'd0, done_valid}, 64'd0);
  endtask

  task automatic setup_three_level;
    mem.delete();
    mem[56'h1000_0028] = mk_pte(44'h20000, 8'h01);
    mem[56'h2000_0038] = mk_pte(44'h30000, 8'h21);
    mem[56'h3000_0048] = mk_pte(44'h45678, 8'hC7);
  endtask

  task automatic t_full_walk(input logic inject);
    logic [38:0] va;
    va = {9'd5, 9'd7, 9'd9, 12'h123};
    setup_three_level();
    walk(va, 2'd0, 1'b0, 1'b0, 1'b0, ROOT, 2'd2, inject);
    check("R9", "ok", {63'd0, r_ok}, 64'd1);
    check("R9", "paddr", r_paddr, 64'h4567_8123);
    check("R9", "pte", r_pte, mk_pte(44'h45678, 8'hC7));
    check("R9", "pte addr", r_pte_addr, 64'h3000_0048);
    check("R9", "level", r_level, 64'd0);
    check("R3", "global or", {63'd0, r_glob}, 64'd1);
    check("R2", "read count", rd_cnt, 64'd3);
    check("R2", "addr L2", rd_log[0], 64'h1000_0028);
    check("R3", "addr L1", rd_log[1], 64'h2000_0038);
    check("R3", "addr L0", rd_log[2], 64'h3000_0048);
    @(negedge clk);
    check("R11", "done pulse drops", {63'd0, done_valid}, 64'd0);
    if (inject) begin
      repeat (4) @(negedge clk);
      check("R11", "no extra reads", rd_cnt, 64'd3);
      check("R11", "still idle", {63'd0, busy}, 64'd0);
    end
  endtask

  task automatic t_access_err;
    setup_three_level();
    err_en = 1'b1; err_addr = 56'h2000_0038;
    walk({9'd5, 9'd7, 9'd9, 12'h123}, 2'd0, 1'b0, 1'b0, 1'b0, ROOT, 2'd2, 1'b0);
    check("R6", "fault", r_fault, 64'd1);
    check("R6", "paddr zero", r_paddr, 64'd0);
    repeat (3) @(negedge clk);
    check("R6", "no further read", rd_cnt, 64'd2);
    err_en = 1'b0;
  endtask

  task automatic t_megapage(input logic [43:0] ppn, input logic [7:0] fl,
                            input logic [2:0] exp_f, input logic [55:0] exp_pa, input string req);
    mem.delete();
    mem[56'h1000_0018] = mk_pte(44'h60000, 8'h01);
    mem[56'h6000_0020] = mk_pte(ppn, fl);
    walk({9'd3, 9'd4, 9'h1AB, 12'hABC}, 2'd0, 1'b0, 1'b0, 1'b0, ROOT, 2'd2, 1'b0);
    check(req, "mega fault", r_fault, {61'd0, exp_f});
    check(req, "mega paddr", r_paddr, {8'd0, exp_pa});
    check(req, "mega level", r_level, 64'd1);
  endtask

  task automatic t_gigapage(input logic [43:0] ppn, input logic [2:0] exp_f,
                            input logic [55:0] exp_pa, input string req);
    mem.delete();
    mem[56'h1000_0030] = mk_pte(ppn, 8'h63);
    walk({9'd6, 9'h055, 9'h0AA, 12'h00F}, 2'd0, 1'b0, 1'b0, 1'b0, ROOT, 2'd2, 1'b0);
    check(req, "giga fault", r_fault, {61'd0, exp_f});
    check(req, "giga paddr", r_paddr, {8'd0, exp_pa});
    check(req, "giga read count", rd_cnt, 64'd1);
    if (exp_f == 3'd0) check("R3", "giga global", {63'd0, r_glob}, 64'd1);
  endtask

  // Leaf at level 0, walk started at level 0
  task automatic t_leaf(input logic [7:0] fl, input logic [1:0] acc, input logic usr,
                        input logic mx, input logic su, input logic [2:0] exp_f, input string req);
    mem.delete();
    mem[56'h7000_0010] = mk_pte(44'h12345, fl);
    walk({9'd0, 9'd0, 9'd2, 12'h0F0}, acc, usr, mx, su, 56'h7000_0000, 2'd0, 1'b0);
    check(req, "leaf fault", r_fault, {61'd0, exp_f});
    check(req, "leaf ok", {63'd0, r_ok}, {63'd0, exp_f == 3'd0});
    check(req, "leaf paddr", r_paddr, (exp_f == 3'd0) ? 64'h1234_50F0 : 64'd0);
  endtask

  task automatic t_bad_level;
    walk(39'h12345, 2'd0, 1'b0, 1'b0, 1'b0, ROOT, 2'd3, 1'b0);
    check("R12", "fault", r_fault, 64'd2);
    check("R12", "no reads", rd_cnt, 64'd0);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_full_walk(1'b0);
    t_full_walk(1'b1);
    t_access_err();
    t_megapage(44'h50200, 8'h4B, 3'd0, 56'h5_03AB_ABC, "R9");
    t_megapage(44'h50201, 8'h4B, 3'd4, 56'h0, "R8");
    t_megapage(44'h50201, 8'h0B, 3'd4, 56'h0, "R8");
    t_gigapage(44'hC0000, 3'd0, 56'hC_AAAA_00F, "R9");
    t_gigapage(44'hC0200, 3'd4, 56'h0, "R8");
    t_leaf(8'hC6, 2'd0, 1'b0, 1'b0, 1'b0, 3'd2, "R5");
    t_leaf(8'hC5, 2'd0, 1'b0, 1'b0, 1'b0, 3'd2, "R5");
    t_leaf(8'h01, 2'd0, 1'b0, 1'b0, 1'b0, 3'd2, "R4");
    t_leaf(8'h43, 2'd1, 1'b0, 1'b0, 1'b0, 3'd3, "R7");
    t_leaf(8'h43, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, "R7");
    t_leaf(8'h43, 2'd3, 1'b0, 1'b0, 1'b0, 3'd0, "R7");
    t_leaf(8'hC7, 2'd0, 1'b1, 1'b0, 1'b0, 3'd3, "R7");
    t_leaf(8'hD7, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0, "R7");
    t_leaf(8'hD7, 2'd0, 1'b0, 1'b0, 1'b0, 3'd3, "R7");
    t_leaf(8'hD7, 2'd0, 1'b0, 1'b0, 1'b1, 3'd0, "R7");
    t_leaf(8'hDF, 2'd2, 1'b0, 1'b0, 1'b1, 3'd3, "R7");
    t_leaf(8'h49, 2'd0, 1'b0, 1'b0, 1'b0, 3'd3, "R7");
    t_leaf(8'h49, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0, "R7");
    t_leaf(8'h49, 2'd2, 1'b0, 1'b0, 1'b0, 3'd0, "R7");
    t_leaf(8'h03, 2'd1, 1'b0, 1'b0, 1'b0, 3'd3, "R7");
    t_leaf(8'h07, 2'd0, 1'b0, 1'b0, 1'b0, 3'd5, "R10");
    t_leaf(8'h47, 2'd1, 1'b0, 1'b0, 1'b0, 3'd5, "R10");
    t_leaf(8'h47, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, "R10");
    t_bad_level();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule